// File: doc/BRIEF.md
# Link Receiver with Stop/Go Slack Buffer

This block is one end of a point-to-point link whose switches forward packets cut-through. A packet moves on as soon as its header arrives. When the path ahead is blocked, the block does not buffer whole packets. It relies on link-level backpressure instead. Each character on the wire is nine bits wide: a flag bit, plus an 8-bit value. A cleared flag marks a data character. A set flag marks a control symbol.

Data characters arriving on the inbound channel go into a queue-ordered slack buffer, and a downstream consumer drains it. The buffer's fill level drives a flow controller with hysteresis:
- When the level climbs to the upper threshold, a single STOP symbol goes out on the outbound channel of the same link.
- When the level drains down to the lower threshold, a single GO symbol goes out.

The upper threshold sits below the buffer depth. The gap equals the headroom needed to absorb the characters still in flight during the round trip.

The same block also carries the local transmitter. That transmitter sends data characters on the outbound channel, where pending control symbols take priority over data. The transmitter also obeys the STOP and GO symbols that the far end sends on the inbound channel.

Top module: `slk_link_port`

## Requirements
- R1: Inbound characters with flag bit 8 clear are stored and delivered on `out_data_o` in arrival order; `out_vld_o` is high exactly when the buffer holds at least one character, and a character leaves when `out_vld_o` and `out_rdy_i` are both high at a clock edge.
- R2: A store and a delivery in the same cycle leave the fill level unchanged and lose or duplicate no character.
- R3: While flowing, a clock edge at which the fill level is at least DEPTH-HEADROOM (24 by default) enters the stopped state. The outbound channel carries the STOP symbol {1, 8'h01} during the following cycle.
- R4: While stopped, a clock edge at which the fill level is at most GO_LVL (8 by default) returns to flowing. The outbound channel carries the GO symbol {1, 8'h02} during the following cycle.
- R5: Each threshold crossing produces its symbol for exactly one cycle, never on consecutive cycles. STOP and GO strictly alternate.
- R6: In a cycle that carries a control symbol, no data character is sent and `tx_rdy_o` is low; the local data character is held for a later cycle.
- R7: An inbound character {1, 8'h01} halts the local transmitter from the next cycle on: `tx_rdy_o` stays low and no data character is sent until an inbound {1, 8'h02} arrives, after which sending resumes in the next cycle.
- R8: An inbound control character with any other value is ignored: it is not stored and does not change the transmitter's halt state.
- R9: If the far end stops within the headroom window, the fill level never exceeds DEPTH.
- R10: After reset the buffer is empty, the flow state is flowing with no symbol pending, and the transmitter is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Inbound channel carries a character this cycle |
| in_char_i | input | 9 | Inbound character: bit 8 is the control flag, bits 7:0 the value |
| out_vld_o | output | 1 | Slack buffer has a character for the consumer |
| out_data_o | output | 8 | Oldest buffered data character |
| out_rdy_i | input | 1 | Consumer takes the character |
| tx_vld_i | input | 1 | Local transmitter offers a data character |
| tx_data_i | input | 8 | Local data character |
| tx_rdy_o | output | 1 | Local data character is sent this cycle |
| lnk_vld_o | output | 1 | Outbound channel carries a character this cycle |
| lnk_char_o | output | 9 | Outbound character: bit 8 is the control flag, bits 7:0 the value |

## Verification
Two kinds of collision need to happen often:
- A control symbol going out in the same cycle that the local transmitter offers data. Holding `tx_vld_i` high throughout the fill-and-drain phases puts every STOP and GO into such a cycle, so the bench can judge whether the symbol wins and the data character is held.
- A store and a delivery landing in the same edge, which stresses the level counter exactly at the thresholds. A dense inbound stream with random and patterned consumer readiness provokes this.

A behavioural queue model predicts every output on every cycle, so a mistaken level, a repeated symbol or a leaked data character shows up in the cycle where it happens.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam int VAL_W = 8;
  localparam logic [VAL_W-1:0] SYM_STOP = 8'h01;
  localparam logic [VAL_W-1:0] SYM_GO   = 8'h02;

  typedef struct packed {
    logic             ctl;
    logic [VAL_W-1:0] val;
  } lchar_t;
endpackage

// File: rtl/slk_fifo.sv
module slk_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_en_i,
  output logic [W-1:0]  rd_data_o,
  output logic          vld_o,
  output logic [CW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign vld_o     = (cnt_q != '0);
  assign do_rd     = rd_en_i && vld_o;
  assign do_wr     = wr_en_i && (cnt_q != CW'(DEPTH));
  assign rd_data_o = mem_q[rd_ptr_q];
  assign level_o   = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_rd) rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (cnt_q != CW'(DEPTH))); // R9
  AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && do_rd) |=> (cnt_q == $past(cnt_q))); // R2
endmodule

// File: rtl/slk_flow.sv
module slk_flow
  import slk_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int HEADROOM = 8,
  parameter int GO_LVL   = 8,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int STOP_LVL = DEPTH - HEADROOM
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    level_i,
  output logic             sym_vld_o,
  output logic [VAL_W-1:0] sym_code_o
);
  logic             stopped_q, pend_q;
  logic [VAL_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_q <= 1'b0;
      pend_q    <= 1'b0;
      code_q    <= SYM_GO;
    end else begin
      pend_q <= 1'b0;
      if (!stopped_q && level_i >= CW'(STOP_LVL)) begin
        stopped_q <= 1'b1;
        pend_q    <= 1'b1;
        code_q    <= SYM_STOP;
      end else if (stopped_q && level_i <= CW'(GO_LVL)) begin
        stopped_q <= 1'b0;
        pend_q    <= 1'b1;
        code_q    <= SYM_GO;
      end
    end
  end

  assign sym_vld_o  = pend_q;
  assign sym_code_o = code_q;

  AST_SYM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q); // R5
  AST_STOP_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && code_q == SYM_STOP) |-> $past(level_i) >= CW'(STOP_LVL)); // R3
  AST_GO_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && code_q == SYM_GO) |-> $past(level_i) <= CW'(GO_LVL)); // R4
endmodule

// File: rtl/slk_txgate.sv
module slk_txgate
  import slk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_ctl_vld_i,
  input  logic [VAL_W-1:0] rx_ctl_val_i,
  input  logic             sym_vld_i,
  input  logic [VAL_W-1:0] sym_code_i,
  input  logic             tx_vld_i,
  input  logic [VAL_W-1:0] tx_data_i,
  output logic             tx_rdy_o,
  output logic             lnk_vld_o,
  output lchar_t           lnk_char_o
);
  logic halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
    end else if (rx_ctl_vld_i) begin
      if (rx_ctl_val_i == SYM_STOP)    halt_q <= 1'b1;
      else if (rx_ctl_val_i == SYM_GO) halt_q <= 1'b0;
    end
  end

  always_comb begin
    tx_rdy_o   = !sym_vld_i && !halt_q;
    lnk_vld_o  = sym_vld_i || (tx_vld_i && !halt_q);
    lnk_char_o = sym_vld_i ? lchar_t'{ctl: 1'b1, val: sym_code_i}
                           : lchar_t'{ctl: 1'b0, val: tx_data_i};
  end

  AST_SYM_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_i |-> (lnk_vld_o && lnk_char_o.ctl && !tx_rdy_o)); // R6
  AST_HALT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctl_vld_i && rx_ctl_val_i == SYM_STOP) |=> !(lnk_vld_o && !lnk_char_o.ctl)); // R7
  AST_ODD_CTL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctl_vld_i && rx_ctl_val_i != SYM_STOP && rx_ctl_val_i != SYM_GO)
      |=> $stable(halt_q)); // R8
endmodule

// File: rtl/slk_link_port.sv
module slk_link_port
  import slk_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int HEADROOM = 8,
  parameter int GO_LVL   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_vld_i,
  input  logic [8:0] in_char_i,
  output logic       out_vld_o,
  output logic [7:0] out_data_o,
  input  logic       out_rdy_i,
  input  logic       tx_vld_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_rdy_o,
  output logic       lnk_vld_o,
  output logic [8:0] lnk_char_o
);
  localparam int CW = $clog2(DEPTH + 1);

  lchar_t           in_c, lnk_c;
  logic             sym_vld;
  logic [VAL_W-1:0] sym_code;
  logic [CW-1:0]    level;

  assign in_c       = lchar_t'(in_char_i);
  assign lnk_char_o = lnk_c;

  slk_fifo #(.DEPTH(DEPTH), .W(VAL_W)) i_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (in_vld_i && !in_c.ctl),
    .wr_data_i (in_c.val),
    .rd_en_i   (out_rdy_i),
    .rd_data_o (out_data_o),
    .vld_o     (out_vld_o),
    .level_o   (level)
  );

  slk_flow #(.DEPTH(DEPTH), .HEADROOM(HEADROOM), .GO_LVL(GO_LVL)) i_flow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level),
    .sym_vld_o  (sym_vld),
    .sym_code_o (sym_code)
  );

  slk_txgate i_txgate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_ctl_vld_i (in_vld_i && in_c.ctl),
    .rx_ctl_val_i (in_c.val),
    .sym_vld_i    (sym_vld),
    .sym_code_i   (sym_code),
    .tx_vld_i     (tx_vld_i),
    .tx_data_i    (tx_data_i),
    .tx_rdy_o     (tx_rdy_o),
    .lnk_vld_o    (lnk_vld_o),
    .lnk_char_o   (lnk_c)
  );

  AST_OUT_STABLE_WHEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && !out_rdy_i) |=> (out_vld_o && $stable(out_data_o))); // R1
endmodule

// File: tb/test_slk_link_port.sv
`timescale 1ns/100ps
module test_slk_link_port;
  localparam int DEPTH = 32, HEADROOM = 8, GO_LVL = 8, LAT = 3;
  localparam int STOP_LVL = DEPTH - HEADROOM;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_vld = 1'b0, out_rdy = 1'b0, tx_vld = 1'b0;
  logic [8:0] in_char = '0;
  logic [7:0] tx_data = '0;
  logic out_vld, tx_rdy, lnk_vld;
  logic [7:0] out_data;
  logic [8:0] lnk_char;

  always #2.5 clk = ~clk;

  slk_link_port i_slk_link_port (
    .clk_i(clk), .rst_ni(rst_ni), .in_vld_i(in_vld), .in_char_i(in_char),
    .out_vld_o(out_vld), .out_data_o(out_data), .out_rdy_i(out_rdy),
    .tx_vld_i(tx_vld), .tx_data_i(tx_data), .tx_rdy_o(tx_rdy),
    .lnk_vld_o(lnk_vld), .lnk_char_o(lnk_char));

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  logic [7:0] q[$];
  bit m_stopped = 0, m_pend = 0, m_halt = 0;
  logic [7:0] m_code = 8'h02;
  int n_stop_m = 0, n_go_m = 0, n_stop_d = 0, n_go_d = 0;
  int max_lvl = 0, both_cnt = 0;
  bit far_halt = 0;
  logic [9:0] dly[LAT];
  logic [7:0] far_seq = 0, tx_seq = 0;
  logic [8:0] inj[$];

  initial begin
    for (int i = 0; i < LAT; i++) dly[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(!out_vld, "R10 out_vld", out_vld, 0);
    chk(!lnk_vld, "R10 lnk_vld", lnk_vld, 0);
    chk(tx_rdy, "R10 tx_rdy", tx_rdy, 1);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit e_ov, e_lv, e_tr, push, pop, odd;
      logic [8:0] e_lc;
      logic [7:0] e_od;
      int cnt;
      @(negedge clk);
      if (cyc == 700)  inj.push_back({1'b1, 8'h01});
      if (cyc == 760)  inj.push_back({1'b1, 8'h02});
      if (cyc == 800)  inj.push_back({1'b1, 8'h55});
      if (cyc == 900)  inj.push_back({1'b1, 8'h01});
      if (cyc == 905)  inj.push_back({1'b1, 8'hA7});
      if (cyc == 930)  inj.push_back({1'b1, 8'h02});
      odd = 0;
      if (inj.size() > 0) begin
        in_char = inj.pop_front(); in_vld = 1'b1;
        odd = (in_char[7:0] != 8'h01 && in_char[7:0] != 8'h02);
      end else if (!far_halt && (cyc % 7 != 6)) begin
        in_char = {1'b0, far_seq}; in_vld = 1'b1; far_seq++;
      end else begin
        in_vld = 1'b0; in_char = {1'b0, 8'hEE};
      end
      if (cyc < 200)       out_rdy = 1'b0;
      else if (cyc < 500)  out_rdy = 1'b1;
      else if (cyc < 1500) out_rdy = (cyc % 3 != 0);
      else                 out_rdy = ($urandom % 4) != 0;
      tx_vld  = (cyc >= 1200) ? (($urandom % 2) != 0) : 1'b1;
      tx_data = tx_seq;
      #1;
      e_ov = q.size() > 0;
      e_od = e_ov ? q[0] : 8'h00;
      e_lv = m_pend || (tx_vld && !m_halt);
      e_lc = m_pend ? {1'b1, m_code} : {1'b0, tx_data};
      e_tr = !m_pend && !m_halt;
      chk(out_vld == e_ov, "R1 out_vld", out_vld, e_ov);
      if (e_ov) chk(out_data == e_od, "R1 order", out_data, e_od);
      chk(lnk_vld == e_lv, m_pend ? "R5 symbol" : "R7 link data", lnk_vld, e_lv);
      if (e_lv) chk(lnk_char == e_lc,
        m_pend ? (m_code == 8'h01 ? "R3 STOP" : "R4 GO") : "R6 data", lnk_char, e_lc);
      chk(tx_rdy == e_tr, m_pend ? "R6 tx_rdy" : "R7 tx_rdy", tx_rdy, e_tr);
      if (lnk_vld && lnk_char == 9'h101) n_stop_d++;
      if (lnk_vld && lnk_char == 9'h102) n_go_d++;
      // far end reacts after LAT cycles
      if (dly[LAT-1][9] && dly[LAT-1][8:0] == 9'h101) far_halt = 1;
      if (dly[LAT-1][9] && dly[LAT-1][8:0] == 9'h102) far_halt = 0;
      for (int i = LAT-1; i > 0; i--) dly[i] = dly[i-1];
      dly[0] = {lnk_vld, lnk_char};
      // model step
      cnt  = q.size();
      pop  = (cnt > 0) && out_rdy;
      push = in_vld && !in_char[8] && (cnt - (pop ? 1 : 0) < DEPTH);
      if (pop && push) both_cnt++;
      if (pop) void'(q.pop_front());
      if (push) q.push_back(in_char[7:0]);
      if (q.size() > max_lvl) max_lvl = q.size();
      m_pend = 0;
      if (!m_stopped && cnt >= STOP_LVL) begin
        m_stopped = 1; m_pend = 1; m_code = 8'h01; n_stop_m++;
      end else if (m_stopped && cnt <= GO_LVL) begin
        m_stopped = 0; m_pend = 1; m_code = 8'h02; n_go_m++;
      end
      if (in_vld && in_char[8]) begin
        if (in_char[7:0] == 8'h01) m_halt = 1;
        else if (in_char[7:0] == 8'h02) m_halt = 0;
      end
      if (e_tr && tx_vld) tx_seq++;
      if (odd) begin
        // R8: odd control value must not be stored nor alter halt
        @(negedge clk); #1;
        chk(out_vld == (q.size() > 0), "R8 no store", out_vld, q.size() > 0);
        chk(tx_rdy == (!m_pend && !m_halt), "R8 halt kept", tx_rdy, !m_pend && !m_halt);
        in_vld = 1'b0;
        // this extra cycle had in_vld from odd char already consumed; re-sync model
        cnt = q.size();
        pop = (cnt > 0) && out_rdy;
        if (pop) void'(q.pop_front());
        m_pend = 0;
        if (!m_stopped && cnt >= STOP_LVL) begin
          m_stopped = 1; m_pend = 1; m_code = 8'h01; n_stop_m++;
        end else if (m_stopped && cnt <= GO_LVL) begin
          m_stopped = 0; m_pend = 1; m_code = 8'h02; n_go_m++;
        end
        if (lnk_vld && lnk_char == 9'h101) n_stop_d++;
        if (lnk_vld && lnk_char == 9'h102) n_go_d++;
        for (int i = LAT-1; i > 0; i--) dly[i] = dly[i-1];
        dly[0] = {lnk_vld, lnk_char};
        if (tx_rdy && tx_vld) tx_seq++;
      end
    end
    chk(n_stop_d == n_stop_m && n_stop_m > 0, "R3 STOP count", n_stop_d, n_stop_m);
    chk(n_go_d == n_go_m && n_go_m > 0, "R4 GO count", n_go_d, n_go_m);
    chk(n_stop_d - n_go_d inside {0, 1}, "R5 alternate", n_stop_d - n_go_d, 0);
    chk(max_lvl <= DEPTH && max_lvl >= STOP_LVL, "R9 max level", max_lvl, DEPTH);
    chk(both_cnt > 0, "R2 simultaneous push pop", both_cnt, 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule